// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs one PHY management transaction at a time over a two-wire serial bus. The wires are a management clock and a bidirectional data line. A request carries a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit data word. When the master accepts a request, it derives the management clock from the system clock through a programmable divider. It then shifts out the whole frame: 32 preamble ones, the start pattern, the opcode and the two addresses.

For a write, the master also drives the turnaround and the data word. For a read, it releases the line from the turnaround onward and captures the word that the PHY returns. Each frame ends with one released idle bit period, after which a single-cycle done pulse is raised. Outputs change only on the falling edge of the management clock, so a PHY that samples on the rising edge always sees stable data.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset, and whenever no frame is running, `mdc_o`, `mdio_oe_o`, `busy_o` and `done_o` are low, and `rdata_o` is zero until the first read completes.
- R2: While a frame runs, `mdc_o` has a period of 2*HALF_DIV system clocks. It is low for the first HALF_DIV clocks of each bit slot and high for the second HALF_DIV clocks.
- R3: Bit slots 0 to 31 carry logic 1 with the output enabled.
- R4: Slots 32 and 33 carry 0 then 1. Slots 34 and 35 carry the opcode: 1,0 when `rd_i`=1 (read) and 0,1 when `rd_i`=0 (write). All four slots have the output enabled.
- R5: Slots 36 to 40 carry the PHY address, MSB first. Slots 41 to 45 carry the register address, MSB first. All ten slots have the output enabled.
- R6: In a write, slots 46 and 47 are driven as 1 then 0. In a read, the output enable is low for both slots.
- R7: In a write, slots 48 to 63 carry `wdata_i` MSB first with the output enabled.
- R8: In a read, the output enable is low in slots 48 to 63. `mdio_i` is sampled at the rising `mdc_o` edge of each of these slots, first sample into bit 15. `rdata_o` holds the word from done until the next read finishes, and write frames leave it unchanged.
- R9: Slot 64 is an idle slot with the output enable low. At its end, `done_o` pulses for exactly one cycle, 130*HALF_DIV cycles after the accepting edge.
- R10: `busy_o` rises on the edge that accepts `start_i` and falls on the edge that raises `done_o`. A `start_i` seen while `busy_o` is high is ignored, and a `start_i` during the done cycle is accepted.
- R11: Within a frame, `mdio_o` and `mdio_oe_o` change only on the system edge where `mdc_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Frame request, taken when not busy |
| rd_i | input | 1 | 1 = read frame, 0 = write frame |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register address |
| wdata_i | input | 16 | Write data |
| mdio_i | input | 1 | Data line as seen at the pad |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data driven onto the line (zero when released) |
| mdio_oe_o | output | 1 | Output enable for the data line |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| rdata_o | output | 16 | Last word captured by a read |

## Verification
The assertions assume that `start_i` is a synchronous level and that `mdio_i` changes only away from the rising management clock edge. They also assume that request fields matter only in the cycle a start is accepted. The stimulus keeps to these assumptions. The bench's PHY model drives `mdio_i` from the bench's own bit count, which advances only at falling-clock slot boundaries, and the bench changes requests and strobes at the falling system edge. One strobe deliberately arrives mid-frame with different fields, to show that the frame underway is left alone.

// File: rtl/mdio_frame_pkg.sv
package mdio_frame_pkg;
  localparam int unsigned PRE_BITS  = 32;
  localparam int unsigned ADDR_W    = 5;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned OP_BASE   = PRE_BITS + 2;
  localparam int unsigned PHY_BASE  = OP_BASE + 2;
  localparam int unsigned REG_BASE  = PHY_BASE + ADDR_W;
  localparam int unsigned TA_BASE   = REG_BASE + ADDR_W;
  localparam int unsigned DATA_BASE = TA_BASE + 2;
  localparam int unsigned IDLE_SLOT = DATA_BASE + DATA_W;
  localparam int unsigned IDX_W     = $clog2(IDLE_SLOT + 1);

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
    logic [DATA_W-1:0] wdata;
  } mgmt_req_t;

  typedef enum logic [2:0] {
    FLD_PRE, FLD_ST, FLD_OP, FLD_PHY, FLD_REG, FLD_TA, FLD_DATA, FLD_IDLE
  } field_e;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             mdc_q;
  logic             tick;

  assign tick = run_i && (cnt_q == CNT_W'(HALF_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = tick & ~mdc_q;
  assign fall_o = tick & mdc_q;
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_frame_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  mgmt_req_t        req_i,
  input  logic             fall_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [IDX_W-1:0] idx_o,
  output mgmt_req_t        req_o
);
  logic             busy_q, done_q;
  logic [IDX_W-1:0] idx_q;
  mgmt_req_t        req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      req_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && start_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        req_q  <= req_i;
      end else if (busy_q && fall_i) begin
        if (idx_q == IDX_W'(IDLE_SLOT)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign idx_o  = idx_q;
  assign req_o  = req_q;
endmodule

// File: rtl/mdio_bit_mux.sv
module mdio_bit_mux
  import mdio_frame_pkg::*;
(
  input  logic             active_i,
  input  logic [IDX_W-1:0] idx_i,
  input  mgmt_req_t        req_i,
  output logic             bit_o,
  output logic             oe_o,
  output logic             rx_slot_o
);
  field_e            fld;
  logic [IDX_W-1:0]  ofs;
  logic [ADDR_W-1:0] phy_sh, reg_sh;
  logic [DATA_W-1:0] dat_sh;
  logic              bit_raw, oe_raw;

  always_comb begin
    if      (idx_i < IDX_W'(PRE_BITS))  begin fld = FLD_PRE;  ofs = idx_i; end
    else if (idx_i < IDX_W'(OP_BASE))   begin fld = FLD_ST;   ofs = idx_i - IDX_W'(PRE_BITS); end
    else if (idx_i < IDX_W'(PHY_BASE))  begin fld = FLD_OP;   ofs = idx_i - IDX_W'(OP_BASE); end
    else if (idx_i < IDX_W'(REG_BASE))  begin fld = FLD_PHY;  ofs = idx_i - IDX_W'(PHY_BASE); end
    else if (idx_i < IDX_W'(TA_BASE))   begin fld = FLD_REG;  ofs = idx_i - IDX_W'(REG_BASE); end
    else if (idx_i < IDX_W'(DATA_BASE)) begin fld = FLD_TA;   ofs = idx_i - IDX_W'(TA_BASE); end
    else if (idx_i < IDX_W'(IDLE_SLOT)) begin fld = FLD_DATA; ofs = idx_i - IDX_W'(DATA_BASE); end
    else                                begin fld = FLD_IDLE; ofs = '0; end
  end

  assign phy_sh = req_i.phy << ofs;
  assign reg_sh = req_i.regad << ofs;
  assign dat_sh = req_i.wdata << ofs;

  always_comb begin
    bit_raw = 1'b0;
    oe_raw  = 1'b1;
    unique case (fld)
      FLD_PRE:  bit_raw = 1'b1;
      FLD_ST:   bit_raw = ofs[0];
      FLD_OP:   bit_raw = req_i.rd ^ ofs[0];
      FLD_PHY:  bit_raw = phy_sh[ADDR_W-1];
      FLD_REG:  bit_raw = reg_sh[ADDR_W-1];
      FLD_TA:   begin oe_raw = ~req_i.rd; bit_raw = ~ofs[0]; end
      FLD_DATA: begin oe_raw = ~req_i.rd; bit_raw = dat_sh[DATA_W-1]; end
      FLD_IDLE: oe_raw = 1'b0;
      default:  oe_raw = 1'b0;
    endcase
  end

  assign oe_o      = active_i & oe_raw;
  assign bit_o     = oe_o & bit_raw;
  assign rx_slot_o = active_i & req_i.rd & (fld == FLD_DATA);
endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] word_o
);
  logic [WIDTH-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_q <= '0;
    else if (shift_i) word_q <= {word_q[WIDTH-2:0], bit_i};
  end

  assign word_o = word_q;
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
  import mdio_frame_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        rd_i,
  input  logic [4:0]  phy_addr_i,
  input  logic [4:0]  reg_addr_i,
  input  logic [15:0] wdata_i,
  input  logic        mdio_i,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] rdata_o
);
  mgmt_req_t        req_in, req_cur;
  logic             busy, rise, fall, rx_slot;
  logic [IDX_W-1:0] idx;

  assign req_in = '{rd: rd_i, phy: phy_addr_i, regad: reg_addr_i, wdata: wdata_i};

  mdio_clk_gen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk_i (clk_i), .rst_ni (rst_ni), .run_i (busy),
    .mdc_o (mdc_o), .rise_o (rise), .fall_o (fall)
  );

  mdio_seq u_seq (
    .clk_i (clk_i), .rst_ni (rst_ni), .start_i (start_i), .req_i (req_in),
    .fall_i (fall), .busy_o (busy), .done_o (done_o), .idx_o (idx), .req_o (req_cur)
  );

  mdio_bit_mux u_mux (
    .active_i (busy), .idx_i (idx), .req_i (req_cur),
    .bit_o (mdio_o), .oe_o (mdio_oe_o), .rx_slot_o (rx_slot)
  );

  mdio_rx_shift #(.WIDTH(DATA_W)) u_rx (
    .clk_i (clk_i), .rst_ni (rst_ni), .shift_i (rise & rx_slot),
    .bit_i (mdio_i), .word_o (rdata_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/mdio_frame_master_chk.sv
module mdio_frame_master_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        mdc_o,
  input logic        mdio_o,
  input logic        mdio_oe_o,
  input logic        busy_o,
  input logic        done_o,
  input logic [15:0] rdata_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mdio_oe_o);

  p_mdc_idle_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mdc_o);

  p_rdata_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(rdata_o));

  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_ends_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $fell(busy_o));

  p_busy_ends_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_start_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !$fell(mdc_o)) |=> busy_o);

  p_change_on_fall_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && !$fell(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));
endmodule

bind mdio_frame_master mdio_frame_master_chk chk_i (
  .clk_i (clk_i), .rst_ni (rst_ni), .start_i (start_i), .mdc_o (mdc_o),
  .mdio_o (mdio_o), .mdio_oe_o (mdio_oe_o), .busy_o (busy_o),
  .done_o (done_o), .rdata_o (rdata_o)
);

// File: tb/mdio_frame_master_tb_top.sv
`timescale 1ns/1ps
module mdio_frame_master_tb_top;
  localparam int HALF      = 2;
  localparam int BIT_CYC   = 2 * HALF;
  localparam int FRAME_CYC = 65 * BIT_CYC;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, rd = 1'b0;
  logic [4:0] pa = '0, ra = '0;
  logic [15:0] wd = '0, phy_word = '0;
  logic mdio_in;
  logic mdc, mdio_out, mdio_oe, busy, done;
  logic [15:0] rdata;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  mdio_frame_master #(.HALF_DIV(HALF)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .rd_i (rd),
    .phy_addr_i (pa), .reg_addr_i (ra), .wdata_i (wd), .mdio_i (mdio_in),
    .mdc_o (mdc), .mdio_o (mdio_out), .mdio_oe_o (mdio_oe),
    .busy_o (busy), .done_o (done), .rdata_o (rdata)
  );

  // behavioural reference
  logic m_busy = 1'b0, m_done = 1'b0, m_rd = 1'b0;
  int   m_cyc = 0;
  logic [63:0] m_frame = '0;
  logic [15:0] m_pword = '0, m_rdata = '0;
  int   bitn;

  assign bitn = m_cyc / BIT_CYC;

  // PHY: drives 0 in the second turnaround slot and the word in the data slots, else pulled up
  assign mdio_in = (m_busy && m_rd && bitn == 47) ? 1'b0 :
                   (m_busy && m_rd && bitn >= 48 && bitn < 64) ? m_pword[63 - bitn] : 1'b1;

  function automatic logic [63:0] build_frame(logic r, logic [4:0] p, logic [4:0] g, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (r ? 2'b10 : 2'b01), p, g, (r ? 2'b00 : 2'b10), (r ? 16'h0 : d)};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_done <= 1'b0; m_cyc <= 0; m_rdata <= '0;
    end else begin
      m_done <= 1'b0;
      if (!m_busy && start) begin
        m_busy  <= 1'b1;
        m_cyc   <= 0;
        m_rd    <= rd;
        m_frame <= build_frame(rd, pa, ra, wd);
        m_pword <= phy_word;
      end else if (m_busy) begin
        if (m_cyc == FRAME_CYC - 1) begin
          m_busy <= 1'b0;
          m_done <= 1'b1;
          if (m_rd) m_rdata <= m_pword;
        end else begin
          m_cyc <= m_cyc + 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic string slot_tag(int b, logic r);
    if (b < 32) return "R3";
    if (b < 36) return "R4";
    if (b < 46) return "R5";
    if (b < 48) return "R6";
    if (b < 64) return r ? "R8" : "R7";
    return "R9";
  endfunction

  bit cmp_en = 1'b0;

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk(busy === m_busy, "R10", "busy", 32'(busy), 32'(m_busy));
      chk(done === m_done, "R9", "done", 32'(done), 32'(m_done));
      if (m_busy) begin
        logic exp_mdc, exp_oe;
        exp_mdc = ((m_cyc / HALF) % 2) == 1;
        exp_oe  = (bitn < 46) || (!m_rd && bitn < 64);
        chk(mdc === exp_mdc, "R2", "mdc", 32'(mdc), 32'(exp_mdc));
        chk(mdio_oe === exp_oe, slot_tag(bitn, m_rd), "oe", 32'(mdio_oe), 32'(exp_oe));
        if (exp_oe)
          chk(mdio_out === m_frame[63 - bitn], slot_tag(bitn, m_rd), "mdio",
              32'(mdio_out), 32'(m_frame[63 - bitn]));
      end else begin
        chk(mdc === 1'b0, "R2", "mdc idle", 32'(mdc), 32'd0);
        chk(mdio_oe === 1'b0, "R1", "oe idle", 32'(mdio_oe), 32'd0);
        chk(rdata === m_rdata, "R8", "rdata", 32'(rdata), 32'(m_rdata));
      end
    end
  end

  task automatic launch(input logic r, input logic [4:0] p, input logic [4:0] g,
                        input logic [15:0] d, input logic [15:0] w);
    start = 1'b1; rd = r; pa = p; ra = g; wd = d; phy_word = w;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!m_done);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(mdc === 1'b0, "R1", "reset mdc", 32'(mdc), 32'd0);
    chk(mdio_oe === 1'b0, "R1", "reset oe", 32'(mdio_oe), 32'd0);
    chk(busy === 1'b0, "R1", "reset busy", 32'(busy), 32'd0);
    chk(done === 1'b0, "R1", "reset done", 32'(done), 32'd0);
    chk(rdata === 16'h0, "R1", "reset rdata", 32'(rdata), 32'd0);
    cmp_en = 1'b1;

    launch(1'b0, 5'h01, 5'h00, 16'hA5C3, 16'h0000);
    wait_done();
    launch(1'b1, 5'h1F, 5'h15, 16'h1234, 16'h8001);
    wait_done();
    // R10: back-to-back start in the done cycle, then a mid-frame start that must be ignored
    launch(1'b0, 5'h10, 5'h0A, 16'hFFFF, 16'h5555);
    repeat (100) @(negedge clk);
    launch(1'b1, 5'h03, 5'h1C, 16'h0F0F, 16'h7E7E);
    wait_done();
    chk(rdata === 16'h8001, "R8", "rdata after write", 32'(rdata), 32'h8001);
    launch(1'b1, 5'h0A, 5'h11, 16'h0000, 16'h3C5A);
    wait_done();
    launch(1'b1, 5'h15, 5'h02, 16'h0000, 16'hFFFF);
    wait_done();
    launch(1'b1, 5'h00, 5'h1F, 16'h0000, 16'h0000);
    wait_done();
    launch(1'b0, 5'h1F, 5'h1F, 16'h0001, 16'hAAAA);
    wait_done();
    repeat (10) @(negedge clk);
    chk(rdata === 16'h0000, "R8", "final rdata", 32'(rdata), 32'h0);
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
    $finish;
  end
endmodule